// File: doc/BRIEF.md
# Parallel Panel Write Sequencer

This block pushes a frame of words onto an 8080-style parallel write bus toward a display panel that keeps its own frame memory. Software programs four strobe timing fields, an interface enable and a frame length in words. It then sets the parallel-panel trigger mode and issues a software trigger in the trigger control register. The block drops chip select, takes one word per strobe from a valid/ready pixel stream, and shapes each write strobe through setup, active and hold phases.

When the last word's hold phase ends, chip select rises, the busy status clears, the trigger mode is left and a frame-done interrupt status bit is raised. That bit drives the interrupt output until software writes 1 to it. A trigger that arrives while a frame is in flight is dropped, so a repeated trigger never disturbs the panel.

Top module: `panel_wr_if`

## Requirements
- R1: After reset the timing register (offset 0) reads 0x0000_0100 (active field 1, all other fields 0, enable 0). Trigger control (offset 1), word count (offset 2) and status (offset 3) read 0. lcd_cs_n and lcd_wr_n are high and irq is low.
- R2: In the timing register, bits 19:16 hold chip-select setup, 15:12 write setup, 11:8 write active, 7:4 write hold and bit 0 the interface enable. While the enable is 0, a trigger starts no transfer.
- R3: A write to trigger control stores bit 0 as the trigger mode. A frame starts only when that write has both bit 0 (mode) and bit 1 (trigger command) set, the interface is enabled and the word count (offset 2) is non-zero. Any other trigger write is ignored.
- R4: After an accepted trigger, the chip-select setup phase lasts CS cycles, once per frame. Each word then takes one handshake cycle, WS cycles of write setup, max(WA,1) cycles with lcd_wr_n low and WH cycles of hold. With the stream always valid, a frame of N words lasts CS + N*(1+WS+max(WA,1)+WH) cycles.
- R5: lcd_cs_n is low from the cycle after the accepted trigger write until the end of the frame's last hold phase, without rising between words. lcd_wr_n is low only while lcd_cs_n is low.
- R6: A word is taken when pix_valid and pix_ready are both high. pix_ready is high only in the handshake cycle. While pix_valid is low the block waits there with lcd_wr_n high. lcd_data holds the taken word unchanged for the whole strobe.
- R7: Status bit 0 (busy) reads 1 from the cycle after the accepted trigger write until the frame ends, and 0 otherwise.
- R8: A trigger write while a frame is in flight, including its final cycle, is ignored and starts no further frame.
- R9: Status bit 1 (frame done) is set as the frame ends, and irq equals it. Writing 1 to status bit 1 clears it and writing 0 leaves it. If a clear and the end of a frame fall in the same cycle, the bit ends up set.
- R10: The trigger mode bit is cleared as the frame ends. This clearing wins over a trigger control write in the same cycle.
- R11: The timing fields and word count are captured when the trigger is accepted. Writes to them during a frame only affect later frames.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 2 | Register offset: 0 timing, 1 trigger, 2 count, 3 status |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for reg_addr |
| pix_valid | input | 1 | Stream word valid |
| pix_ready | output | 1 | Stream word accepted this cycle when valid |
| pix_data | input | DATA_W | Stream word |
| lcd_cs_n | output | 1 | Panel chip select, active low |
| lcd_wr_n | output | 1 | Panel write strobe, active low |
| lcd_data | output | DATA_W | Panel data bus |
| irq | output | 1 | Frame-done interrupt, level |

## Verification
Two events can share the frame's final cycle: the sequencer's completion, and a software register write. The write may be a new trigger command or a write-1 clear of the done bit. The bench counts cycles from a trigger it issued and places each write so it lands on that final edge. It then judges the result at the ports and registers. The re-trigger must leave chip select high, busy low and the trigger mode cleared. The clear must leave irq high.

// File: rtl/panel_wr_pkg.sv
package panel_wr_pkg;

    // Register map geometry (field positions are decoded by software)
    localparam int REG_W      = 32;
    localparam int PH_W       = 4;
    localparam int TIM_CS_LSB = 16;
    localparam int TIM_WS_LSB = 12;
    localparam int TIM_WA_LSB = 8;
    localparam int TIM_WH_LSB = 4;
    localparam int TIM_EN_BIT = 0;
    localparam int TRG_MODE_BIT = 0;
    localparam int TRG_CMD_BIT  = 1;
    localparam int STS_BUSY_BIT = 0;
    localparam int STS_DONE_BIT = 1;

    localparam logic [1:0] ADDR_TIMING = 2'd0;
    localparam logic [1:0] ADDR_TRIG   = 2'd1;
    localparam logic [1:0] ADDR_COUNT  = 2'd2;
    localparam logic [1:0] ADDR_STATUS = 2'd3;

    localparam logic [PH_W-1:0] ACT_RESET = PH_W'(1);

    typedef enum logic [2:0] {
        PH_IDLE,
        PH_CSU,
        PH_WAIT,
        PH_WSU,
        PH_ACT,
        PH_HLD
    } phase_e;

    typedef struct packed {
        logic [PH_W-1:0] cs;
        logic [PH_W-1:0] ws;
        logic [PH_W-1:0] wa;
        logic [PH_W-1:0] wh;
    } timing_t;

    // Remaining-count load for the active phase: never shorter than one cycle
    function automatic logic [PH_W-1:0] act_load(input logic [PH_W-1:0] wa);
        return (wa == '0) ? '0 : wa - PH_W'(1);
    endfunction

endpackage

// File: rtl/panel_wr_regs.sv
module panel_wr_regs
    import panel_wr_pkg::*;
#(
    parameter int CNT_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             reg_we,
    input  logic [1:0]       reg_addr,
    input  logic [REG_W-1:0] reg_wdata,
    output logic [REG_W-1:0] reg_rdata,
    input  logic             busy,
    input  logic             frame_done,
    output timing_t          tim,
    output logic [CNT_W-1:0] count,
    output logic             start,
    output logic             done
);

    typedef struct packed {
        timing_t          tim;
        logic             en;
        logic             mode;
        logic [CNT_W-1:0] count;
        logic             done;
    } regs_t;

    localparam regs_t REGS_RESET = '{
        tim:   '{cs: '0, ws: '0, wa: ACT_RESET, wh: '0},
        en:    1'b0,
        mode:  1'b0,
        count: '0,
        done:  1'b0
    };

    regs_t regs_q, regs_d;
    logic  unused_wdata;

    assign unused_wdata = ^reg_wdata;

    always_comb begin
        regs_d = regs_q;
        start  = 1'b0;
        if (reg_we) begin
            case (reg_addr)
                ADDR_TIMING: begin
                    regs_d.tim.cs = reg_wdata[TIM_CS_LSB +: PH_W];
                    regs_d.tim.ws = reg_wdata[TIM_WS_LSB +: PH_W];
                    regs_d.tim.wa = reg_wdata[TIM_WA_LSB +: PH_W];
                    regs_d.tim.wh = reg_wdata[TIM_WH_LSB +: PH_W];
                    regs_d.en     = reg_wdata[TIM_EN_BIT];
                end
                ADDR_TRIG: begin
                    regs_d.mode = reg_wdata[TRG_MODE_BIT];
                    start = reg_wdata[TRG_MODE_BIT] & reg_wdata[TRG_CMD_BIT]
                          & regs_q.en & ~busy & (regs_q.count != '0);
                end
                ADDR_COUNT: regs_d.count = reg_wdata[CNT_W-1:0];
                ADDR_STATUS: begin
                    if (reg_wdata[STS_DONE_BIT]) regs_d.done = 1'b0;
                end
                default: ;
            endcase
        end
        // completion outranks any same-cycle software write
        if (frame_done) begin
            regs_d.done = 1'b1;
            regs_d.mode = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) regs_q <= REGS_RESET;
        else        regs_q <= regs_d;
    end

    always_comb begin
        reg_rdata = '0;
        case (reg_addr)
            ADDR_TIMING: begin
                reg_rdata[TIM_CS_LSB +: PH_W] = regs_q.tim.cs;
                reg_rdata[TIM_WS_LSB +: PH_W] = regs_q.tim.ws;
                reg_rdata[TIM_WA_LSB +: PH_W] = regs_q.tim.wa;
                reg_rdata[TIM_WH_LSB +: PH_W] = regs_q.tim.wh;
                reg_rdata[TIM_EN_BIT]         = regs_q.en;
            end
            ADDR_TRIG:   reg_rdata[TRG_MODE_BIT] = regs_q.mode;
            ADDR_COUNT:  reg_rdata = REG_W'(regs_q.count);
            ADDR_STATUS: begin
                reg_rdata[STS_BUSY_BIT] = busy;
                reg_rdata[STS_DONE_BIT] = regs_q.done;
            end
            default: ;
        endcase
    end

    assign tim   = regs_q.tim;
    assign count = regs_q.count;
    assign done  = regs_q.done;

endmodule

// File: rtl/panel_wr_seq.sv
module panel_wr_seq
    import panel_wr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start,
    input  timing_t           tim_in,
    input  logic [CNT_W-1:0]  count_in,
    input  logic              pix_valid,
    input  logic [DATA_W-1:0] pix_data,
    output logic              pix_ready,
    output logic              lcd_cs_n,
    output logic              lcd_wr_n,
    output logic [DATA_W-1:0] lcd_data,
    output logic              busy,
    output logic              frame_done
);

    typedef struct packed {
        phase_e            ph;
        logic [PH_W-1:0]   cnt;
        logic [CNT_W-1:0]  left;
        logic [DATA_W-1:0] data;
        timing_t           tim;
        logic              cs_n;
        logic              wr_n;
    } seq_t;

    localparam seq_t SEQ_RESET = '{
        ph:   PH_IDLE,
        cnt:  '0,
        left: '0,
        data: '0,
        tim:  '{cs: '0, ws: '0, wa: ACT_RESET, wh: '0},
        cs_n: 1'b1,
        wr_n: 1'b1
    };

    seq_t seq_q, seq_d;
    logic word_end;
    logic cnt_zero;

    assign cnt_zero = (seq_q.cnt == '0);

    always_comb begin
        seq_d      = seq_q;
        word_end   = 1'b0;
        frame_done = 1'b0;
        case (seq_q.ph)
            PH_IDLE: begin
                if (start) begin
                    seq_d.tim  = tim_in;
                    seq_d.left = count_in;
                    if (tim_in.cs != '0) begin
                        seq_d.ph  = PH_CSU;
                        seq_d.cnt = tim_in.cs - PH_W'(1);
                    end else begin
                        seq_d.ph  = PH_WAIT;
                    end
                end
            end
            PH_CSU: begin
                if (cnt_zero) seq_d.ph  = PH_WAIT;
                else          seq_d.cnt = seq_q.cnt - PH_W'(1);
            end
            PH_WAIT: begin
                if (pix_valid) begin
                    seq_d.data = pix_data;
                    if (seq_q.tim.ws != '0) begin
                        seq_d.ph  = PH_WSU;
                        seq_d.cnt = seq_q.tim.ws - PH_W'(1);
                    end else begin
                        seq_d.ph  = PH_ACT;
                        seq_d.cnt = act_load(seq_q.tim.wa);
                    end
                end
            end
            PH_WSU: begin
                if (cnt_zero) begin
                    seq_d.ph  = PH_ACT;
                    seq_d.cnt = act_load(seq_q.tim.wa);
                end else begin
                    seq_d.cnt = seq_q.cnt - PH_W'(1);
                end
            end
            PH_ACT: begin
                if (cnt_zero) begin
                    if (seq_q.tim.wh != '0) begin
                        seq_d.ph  = PH_HLD;
                        seq_d.cnt = seq_q.tim.wh - PH_W'(1);
                    end else begin
                        word_end = 1'b1;
                    end
                end else begin
                    seq_d.cnt = seq_q.cnt - PH_W'(1);
                end
            end
            PH_HLD: begin
                if (cnt_zero) word_end  = 1'b1;
                else          seq_d.cnt = seq_q.cnt - PH_W'(1);
            end
            default: seq_d.ph = PH_IDLE;
        endcase

        if (word_end) begin
            if (seq_q.left <= CNT_W'(1)) begin
                seq_d.ph   = PH_IDLE;
                frame_done = 1'b1;
            end else begin
                seq_d.ph   = PH_WAIT;
                seq_d.left = seq_q.left - CNT_W'(1);
            end
        end

        seq_d.cs_n = (seq_d.ph == PH_IDLE);
        seq_d.wr_n = (seq_d.ph != PH_ACT);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) seq_q <= SEQ_RESET;
        else        seq_q <= seq_d;
    end

    assign pix_ready = (seq_q.ph == PH_WAIT);
    assign busy      = (seq_q.ph != PH_IDLE);
    assign lcd_cs_n  = seq_q.cs_n;
    assign lcd_wr_n  = seq_q.wr_n;
    assign lcd_data  = seq_q.data;

endmodule

// File: rtl/panel_wr_if.sv
module panel_wr_if
    import panel_wr_pkg::*;
#(
    parameter int DATA_W = 16,
    parameter int CNT_W  = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_we,
    input  logic [1:0]        reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic [31:0]       reg_rdata,
    input  logic              pix_valid,
    output logic              pix_ready,
    input  logic [DATA_W-1:0] pix_data,
    output logic              lcd_cs_n,
    output logic              lcd_wr_n,
    output logic [DATA_W-1:0] lcd_data,
    output logic              irq
);

    timing_t          tim;
    logic [CNT_W-1:0] count;
    logic             start;
    logic             busy;
    logic             frame_done;
    logic             done;

    panel_wr_regs #(.CNT_W(CNT_W)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .reg_we     (reg_we),
        .reg_addr   (reg_addr),
        .reg_wdata  (reg_wdata),
        .reg_rdata  (reg_rdata),
        .busy       (busy),
        .frame_done (frame_done),
        .tim        (tim),
        .count      (count),
        .start      (start),
        .done       (done)
    );

    panel_wr_seq #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
        .clk        (clk),
        .rst_n      (rst_n),
        .start      (start),
        .tim_in     (tim),
        .count_in   (count),
        .pix_valid  (pix_valid),
        .pix_data   (pix_data),
        .pix_ready  (pix_ready),
        .lcd_cs_n   (lcd_cs_n),
        .lcd_wr_n   (lcd_wr_n),
        .lcd_data   (lcd_data),
        .busy       (busy),
        .frame_done (frame_done)
    );

    assign irq = done;

endmodule

// File: rtl/panel_wr_if_chk.sv
module panel_wr_if_chk #(
    parameter int DATA_W = 16
) (
    input logic              clk,
    input logic              rst_n,
    input logic              pix_valid,
    input logic              pix_ready,
    input logic              lcd_cs_n,
    input logic              lcd_wr_n,
    input logic [DATA_W-1:0] lcd_data,
    input logic              irq
);

    // R5
    strobe_inside_cs_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !lcd_wr_n |-> !lcd_cs_n);

    // R6
    no_strobe_in_wait_chk: assert property (@(posedge clk) disable iff (!rst_n)
        pix_ready |-> lcd_wr_n);

    // R6
    stall_holds_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pix_ready && !pix_valid) |=> (pix_ready && lcd_wr_n));

    // R6
    data_steady_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!lcd_wr_n && !$past(lcd_wr_n)) |-> $stable(lcd_data));

    // R9
    done_at_frame_end_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(irq) |-> (lcd_cs_n && !$past(lcd_cs_n)));

endmodule

bind panel_wr_if panel_wr_if_chk #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .pix_valid (pix_valid),
    .pix_ready (pix_ready),
    .lcd_cs_n  (lcd_cs_n),
    .lcd_wr_n  (lcd_wr_n),
    .lcd_data  (lcd_data),
    .irq       (irq)
);

// File: tb/panel_wr_if_test.sv
module panel_wr_if_test;

    localparam int CLK_PERIOD = 10;
    localparam int DATA_W     = 16;
    localparam int CNT_W      = 16;
    localparam int NVEC       = 5;

    // {cs, ws, wa, wh, words, busy cycles, cycles before first strobe, strobe width}
    localparam logic [43:0] VEC [NVEC] = '{
        {4'd0,  4'd0,  4'd1,  4'd0,  8'd1, 8'd2,   8'd1,  4'd1},
        {4'd0,  4'd0,  4'd0,  4'd0,  8'd3, 8'd6,   8'd1,  4'd1},
        {4'd2,  4'd1,  4'd3,  4'd1,  8'd2, 8'd14,  8'd4,  4'd3},
        {4'd15, 4'd15, 4'd15, 4'd15, 8'd2, 8'd107, 8'd31, 4'd15},
        {4'd3,  4'd0,  4'd2,  4'd4,  8'd4, 8'd31,  8'd4,  4'd2}
    };

    logic              clk;
    logic              rst_n;
    logic              reg_we;
    logic [1:0]        reg_addr;
    logic [31:0]       reg_wdata;
    logic [31:0]       reg_rdata;
    logic              pix_valid;
    logic              pix_ready;
    logic [DATA_W-1:0] pix_data;
    logic              lcd_cs_n;
    logic              lcd_wr_n;
    logic [DATA_W-1:0] lcd_data;
    logic              irq;

    int checks = 0;
    int fails  = 0;

    // monitor state
    int cs_cnt, low_cnt, pulses, first_off, data_err, mon_idx;
    logic first_seen, prev_wr;
    // stream state
    int src_idx, gap;
    logic hs, stall_en;

    panel_wr_if #(.DATA_W(DATA_W), .CNT_W(CNT_W)) uut (
        .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .pix_valid(pix_valid),
        .pix_ready(pix_ready), .pix_data(pix_data), .lcd_cs_n(lcd_cs_n),
        .lcd_wr_n(lcd_wr_n), .lcd_data(lcd_data), .irq(irq)
    );

    initial clk = 1'b0;
    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [DATA_W-1:0] word_of(input int k);
        return DATA_W'((k * 32'h1357) ^ 32'h5A5A);
    endfunction

    task automatic report;
        $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    endtask

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [1:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1'b1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 1'b0;
    endtask

    task automatic rd(input logic [1:0] a, output logic [31:0] d);
        @(negedge clk);
        reg_addr = a;
        #1 d = reg_rdata;
    endtask

    task automatic clear_meas;
        cs_cnt = 0; low_cnt = 0; pulses = 0; first_off = -1;
        data_err = 0; first_seen = 1'b0;
    endtask

    task automatic setup_frame(input logic [31:0] timing, input int n);
        wr(2'd2, n);
        wr(2'd0, timing);
    endtask

    task automatic wait_done;
        for (int k = 0; k < 2000 && !irq; k++) @(negedge clk);
    endtask

    // stream source
    initial begin
        pix_valid = 1'b0; pix_data = '0; src_idx = 0; gap = 0; hs = 1'b0; stall_en = 1'b0;
        forever begin
            @(negedge clk);
            if (hs) begin
                src_idx++;
                if (stall_en) gap = 3;
            end
            if (gap > 0) begin
                pix_valid = 1'b0;
                gap--;
            end else begin
                pix_valid = 1'b1;
            end
            pix_data = word_of(src_idx);
            hs = pix_valid && pix_ready;
        end
    end

    // bus monitor
    initial begin
        mon_idx = 0; prev_wr = 1'b1;
        clear_meas();
        forever begin
            @(negedge clk);
            if (!lcd_cs_n) cs_cnt++;
            if (!lcd_wr_n) begin
                low_cnt++;
                if (!first_seen) begin
                    first_off  = cs_cnt - 1;
                    first_seen = 1'b1;
                end
                if (prev_wr) pulses++;
                if (lcd_data !== word_of(mon_idx)) data_err++;
            end
            if (!prev_wr && lcd_wr_n) mon_idx++;
            prev_wr = lcd_wr_n;
        end
    end

    // watchdog
    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog: actual running expected finished");
        report();
        $finish;
    end

    initial begin
        logic [31:0] r;
        rst_n = 1'b0; reg_we = 1'b0; reg_addr = '0; reg_wdata = '0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;

        // R1 reset state
        rd(2'd0, r); check("R1 timing reset", r, 32'h0000_0100);
        rd(2'd1, r); check("R1 trigger reset", r, 32'h0);
        rd(2'd2, r); check("R1 count reset", r, 32'h0);
        rd(2'd3, r); check("R1 status reset", r, 32'h0);
        check("R1 cs_n reset", lcd_cs_n, 1'b1);
        check("R1 wr_n reset", lcd_wr_n, 1'b1);
        check("R1 irq reset", irq, 1'b0);

        // R3 zero count ignored
        wr(2'd0, 32'h0000_0101);
        wr(2'd1, 32'h3);
        rd(2'd3, r); check("R3 zero count no start", r, 32'h0);
        // R2 disabled interface ignored
        wr(2'd2, 2);
        wr(2'd0, 32'h0000_0100);
        wr(2'd1, 32'h3);
        rd(2'd3, r); check("R2 enable clear no start", r, 32'h0);
        check("R2 cs_n stays high", lcd_cs_n, 1'b1);
        // R3 command without mode bit ignored
        wr(2'd0, 32'h0000_0101);
        wr(2'd1, 32'h2);
        rd(2'd3, r); check("R3 mode clear no start", r, 32'h0);
        repeat (3) @(negedge clk);
        check("R3 no strobes from ignored triggers", pulses, 0);

        // vector walk: R4 R5 R6 R7 R9 R10
        for (int i = 0; i < NVEC; i++) begin
            logic [43:0] v;
            logic [31:0] tw;
            v  = VEC[i];
            tw = {12'h0, v[43:40], v[39:36], v[35:32], v[31:28], 4'b0001};
            clear_meas();
            setup_frame(tw, int'(v[27:20]));
            wr(2'd1, 32'h3);
            rd(2'd3, r); check("R7 busy after trigger", r[0], 1'b1);
            wait_done();
            check("R5 chip select low cycles", cs_cnt, int'(v[19:12]));
            check("R4 cycles before first strobe", first_off, int'(v[11:4]));
            check("R4 strobe low cycles", low_cnt, int'(v[27:20]) * int'(v[3:0]));
            check("R6 strobes per frame", pulses, int'(v[27:20]));
            check("R6 data on bus", data_err, 0);
            rd(2'd3, r); check("R9 status done not busy", r, 32'h2);
            rd(2'd1, r); check("R10 trigger mode left", r, 32'h0);
            wr(2'd3, 32'h0);
            @(negedge clk); check("R9 write 0 keeps done", irq, 1'b1);
            wr(2'd3, 32'h2);
            @(negedge clk); check("R9 write 1 clears done", irq, 1'b0);
        end

        // R6 stall: valid low three cycles after every word
        stall_en = 1'b1;
        clear_meas();
        setup_frame(32'h0000_0001, 3);
        wr(2'd1, 32'h3);
        wait_done();
        stall_en = 1'b0;
        check("R6 stall frame length", cs_cnt, 10);
        check("R6 stall strobes", pulses, 3);
        check("R6 stall strobe low cycles", low_cnt, 3);
        check("R6 stall data", data_err, 0);
        wr(2'd3, 32'h2);

        // R8 trigger during frame ignored
        clear_meas();
        setup_frame(32'h0002_1311, 2);
        wr(2'd1, 32'h3);
        wr(2'd1, 32'h3);
        wait_done();
        repeat (5) @(negedge clk);
        check("R8 frame length unchanged", cs_cnt, 14);
        check("R8 no second frame", pulses, 2);
        check("R8 cs_n high after", lcd_cs_n, 1'b1);
        wr(2'd3, 32'h2);

        // R11 writes during a frame affect only the next one
        clear_meas();
        setup_frame(32'h0000_0201, 2);
        wr(2'd1, 32'h3);
        wr(2'd0, 32'h0000_0501);
        wr(2'd2, 1);
        wait_done();
        check("R11 old strobe width kept", low_cnt, 4);
        check("R11 old frame length kept", cs_cnt, 6);
        check("R11 old count kept", pulses, 2);
        wr(2'd3, 32'h2);
        clear_meas();
        wr(2'd1, 32'h3);
        wait_done();
        check("R11 new strobe width", low_cnt, 5);
        check("R11 new count", pulses, 1);
        check("R11 new frame length", cs_cnt, 6);
        wr(2'd3, 32'h2);

        // R8 R10 trigger landing on the final edge of a 5-cycle frame
        clear_meas();
        setup_frame(32'h0001_0101, 2);
        wr(2'd1, 32'h3);
        repeat (3) @(negedge clk);
        wr(2'd1, 32'h3);
        repeat (4) @(negedge clk);
        check("R8 final-cycle trigger cs_n", lcd_cs_n, 1'b1);
        check("R8 final-cycle trigger frame length", cs_cnt, 5);
        check("R8 final-cycle trigger strobes", pulses, 2);
        rd(2'd3, r); check("R8 final-cycle trigger status", r, 32'h2);
        rd(2'd1, r); check("R10 completion clears mode over write", r, 32'h0);
        wr(2'd3, 32'h2);

        // R9 clear landing on the final edge: set wins
        clear_meas();
        wr(2'd1, 32'h3);
        repeat (3) @(negedge clk);
        wr(2'd3, 32'h2);
        repeat (2) @(negedge clk);
        check("R9 set wins over clear", irq, 1'b1);
        check("R9 frame length", cs_cnt, 5);

        report();
        $finish;
    end

endmodule